// File: doc/BRIEF.md
# Memory-Mapped Translation Entry Table

This block holds a table of address-translation entries and exposes them to software through three register windows on a simple single-cycle bus. The tag window carries the virtual page number, the dirty and valid flags and the address-space identifier. The first attribute window carries the physical page number, the valid flag, the page size, the protection bits and the cache and dirty controls. The second attribute window carries the space attribute and the timing-control bit. Each window finds the entry from the access address, packs that entry's fields into a 32-bit word on reads and unpacks a 32-bit word into the fields on writes. The valid and dirty flags are each stored once per entry, so both the tag window and the first attribute window reach the same bit.

A separate combinational port rewrites store-queue addresses in 1 MB units. When translation is off, the address passes through. When it is on, the port compares the top twelve address bits with the top twelve bits of each entry's virtual page. On a hit it substitutes the entry's physical top twelve bits. The lowest-numbered matching entry wins. An associative-mode write to the tag window is not supported: it changes nothing and pulses an error output.

Top module: `tlb_mmio_array`

## Requirements
- R1: After reset every field of every entry is zero, so every window reads 0, and `assoc_err` is low.
- R2: Bus address bit 24 low selects the tag window. Bit 24 high with bit 23 low selects attribute window 1. Bits 24 and 23 both high select attribute window 2. Address bits 13:8 give the entry index.
- R3: A tag-window write with address bit 7 low stores data[31:10] as the virtual page, data[9] as dirty, data[8] as valid and data[7:0] as the space identifier. A read returns the same layout.
- R4: Tag-window reads return the same word whether address bit 7 is 0 or 1.
- R5: Attribute window 1 maps these fields to these bits: physical page at 28:10, valid at 8, page size split with its high bit at 7 and its low bit at 4, protection at 6:5, cacheable at 3, dirty at 2, shared at 1 and write-through at 0. Bits 31:29 and 9 read as zero.
- R6: Attribute window 2 holds timing control at bit 3 and the space attribute at bits 2:0. Bits 31:4 are ignored on write and read as zero, and a write there leaves attribute window 1 of the same entry unchanged.
- R7: Valid and dirty are one bit each per entry. A write through either the tag window or attribute window 1 is seen on reads through both.
- R8: Read data appears on `bus_rdata` at the clock edge that accepts the read. It holds its value until the next read is accepted.
- R9: With `xlate_en` low, `sq_addr_out` equals `sq_addr_in`.
- R10: With `xlate_en` high and an entry whose virtual page bits 31:20 equal `sq_addr_in[31:20]`, `sq_addr_out` is the entry's physical page bits 31:20 (page shifted left by 10) joined with `sq_addr_in[19:0]`. This holds for the highest entry index too.
- R11: With `xlate_en` high and no matching entry, `sq_addr_out` equals `sq_addr_in`.
- R12: When several entries match, the lowest-indexed one supplies the physical bits.
- R13: A tag-window write with address bit 7 high changes no entry. It drives `assoc_err` high for exactly the one cycle after the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Access address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| assoc_err | output | 1 | One-cycle pulse after an unsupported associative write |
| xlate_en | input | 1 | Translation enable for the remap port |
| sq_addr_in | input | 32 | Store-queue address to remap |
| sq_addr_out | output | 32 | Remapped address |

## Verification
The bench builds the block with its default of 64 entries. Index 0 and index 63 are therefore both reachable through the full six-bit index field. The remap search runs over the complete comparator chain: priority is shown between entries 2, 40 and 50, and a match found only at entry 63 is shown at the far end of the chain. Split-field packing is checked with all-ones and mixed patterns. These show which bits are dropped, and that the shared valid and dirty flags cross between windows.

// File: rtl/tlb_mmio_array.sv
module tlb_mmio_array #(
  parameter int ENTRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_vld,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        assoc_err,
  input  logic        xlate_en,
  input  logic [31:0] sq_addr_in,
  output logic [31:0] sq_addr_out
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [21:0] vpn_q  [ENTRIES];
  logic [18:0] ppn_q  [ENTRIES];
  logic [7:0]  asid_q [ENTRIES];
  logic [1:0]  size_q [ENTRIES];
  logic [1:0]  prot_q [ENTRIES];
  logic [2:0]  spc_q  [ENTRIES];
  logic        vld_q  [ENTRIES];
  logic        drt_q  [ENTRIES];
  logic        shr_q  [ENTRIES];
  logic        cch_q  [ENTRIES];
  logic        wrt_q  [ENTRIES];
  logic        tmc_q  [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic win_tag, win_at1, win_at2, assoc_wr;
  logic [31:0] rd_word;

  assign idx      = bus_addr[8 +: IDX_W];
  assign win_tag  = !bus_addr[24];
  assign win_at1  = bus_addr[24] && !bus_addr[23];
  assign win_at2  = bus_addr[24] && bus_addr[23];
  assign assoc_wr = bus_vld && bus_we && win_tag && bus_addr[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        ppn_q[i]  <= '0;
        asid_q[i] <= '0;
        size_q[i] <= '0;
        prot_q[i] <= '0;
        spc_q[i]  <= '0;
        vld_q[i]  <= 1'b0;
        drt_q[i]  <= 1'b0;
        shr_q[i]  <= 1'b0;
        cch_q[i]  <= 1'b0;
        wrt_q[i]  <= 1'b0;
        tmc_q[i]  <= 1'b0;
      end
    end else if (bus_vld && bus_we) begin
      if (win_tag && !bus_addr[7]) begin
        vpn_q[idx]  <= bus_wdata[31:10];
        drt_q[idx]  <= bus_wdata[9];
        vld_q[idx]  <= bus_wdata[8];
        asid_q[idx] <= bus_wdata[7:0];
      end
      if (win_at1) begin
        ppn_q[idx]  <= bus_wdata[28:10];
        vld_q[idx]  <= bus_wdata[8];
        size_q[idx] <= {bus_wdata[7], bus_wdata[4]};
        prot_q[idx] <= bus_wdata[6:5];
        cch_q[idx]  <= bus_wdata[3];
        drt_q[idx]  <= bus_wdata[2];
        shr_q[idx]  <= bus_wdata[1];
        wrt_q[idx]  <= bus_wdata[0];
      end
      if (win_at2) begin
        tmc_q[idx] <= bus_wdata[3];
        spc_q[idx] <= bus_wdata[2:0];
      end
    end
  end

  always_comb begin
    if (win_tag)
      rd_word = {vpn_q[idx], drt_q[idx], vld_q[idx], asid_q[idx]};
    else if (win_at1)
      rd_word = {3'b000, ppn_q[idx], 1'b0, vld_q[idx], size_q[idx][1],
                 prot_q[idx], size_q[idx][0], cch_q[idx], drt_q[idx],
                 shr_q[idx], wrt_q[idx]};
    else
      rd_word = {28'd0, tmc_q[idx], spc_q[idx]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      assoc_err <= 1'b0;
    end else begin
      assoc_err <= assoc_wr;
      if (bus_vld && !bus_we) bus_rdata <= rd_word;
    end
  end

  logic       hit;
  logic [8:0] hit_ppn;

  always_comb begin
    hit     = 1'b0;
    hit_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vpn_q[i][21:10] == sq_addr_in[31:20]) begin
        hit     = 1'b1;
        hit_ppn = ppn_q[i][18:10];
      end
    end
  end

  assign sq_addr_out = (xlate_en && hit) ? {3'b000, hit_ppn, sq_addr_in[19:0]}
                                         : sq_addr_in;
endmodule

module tlb_mmio_array_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_vld,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_rdata,
  input logic        assoc_err,
  input logic        xlate_en,
  input logic [31:0] sq_addr_in,
  input logic [31:0] sq_addr_out
);
  a_r13_err_after_assoc: assert property (@(posedge clk) disable iff (!rst_n)
    assoc_err |-> $past(bus_vld && bus_we && !bus_addr[24] && bus_addr[7]));

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_vld && !bus_we) |-> $stable(bus_rdata));

  a_r6_at2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_vld && !bus_we && bus_addr[24] && bus_addr[23]) |-> bus_rdata[31:4] == 28'd0);

  a_r5_at1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_vld && !bus_we && bus_addr[24] && !bus_addr[23])
      |-> (bus_rdata[31:29] == 3'b000 && !bus_rdata[9]));

  a_r9_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> sq_addr_out == sq_addr_in);

  a_r10_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    sq_addr_out[19:0] == sq_addr_in[19:0]);
endmodule

bind tlb_mmio_array tlb_mmio_array_chk u_chk (.*);

// File: tb/tb_tlb_mmio_array.sv
module tb_tlb_mmio_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        assoc_err;
  logic        xlate_en = 1'b0;
  logic [31:0] sq_addr_in = '0;
  logic [31:0] sq_addr_out;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] TAG = 32'hF600_0000;
  localparam logic [31:0] AT1 = 32'hF700_0000;
  localparam logic [31:0] AT2 = 32'hF780_0000;

  always #2 clk = ~clk;

  tlb_mmio_array dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] base, input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = base | (idx << 8); bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] addr, output logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b0; bus_addr = addr;
    @(negedge clk);
    bus_vld = 1'b0;
    d = bus_rdata;
  endtask

  task automatic remap(input logic en, input logic [31:0] a, output logic [31:0] o);
    @(negedge clk);
    xlate_en = en; sq_addr_in = a;
    #1 o = sq_addr_out;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 assoc_err", {31'd0, assoc_err}, 32'd0);
    rd(TAG | (5 << 8), d);  check("R1 tag entry 5", d, 32'd0);
    rd(AT1 | (63 << 8), d); check("R1 at1 entry 63", d, 32'd0);
    rd(AT2 | (0 << 8), d);  check("R1 at2 entry 0", d, 32'd0);
  endtask

  task automatic t_tag;
    logic [31:0] d;
    wr(TAG, 3, 32'hABCD_E7A5);
    rd(TAG | (3 << 8), d);         check("R3 tag pack", d, 32'hABCD_E7A5);
    rd(TAG | (3 << 8) | 32'h80, d); check("R4 tag read bit7 ignored", d, 32'hABCD_E7A5);
    rd(TAG | (4 << 8), d);         check("R2 neighbour entry untouched", d, 32'd0);
  endtask

  task automatic t_at1;
    logic [31:0] d;
    wr(AT1, 12, 32'h0ABC_D496);
    rd(AT1 | (12 << 8), d); check("R5 at1 mixed pack", d, 32'h0ABC_D496);
    wr(AT1, 13, 32'hFFFF_FFFF);
    rd(AT1 | (13 << 8), d); check("R5 at1 unused bits zero", d, 32'h1FFF_FDFF);
    rd(TAG | (13 << 8), d); check("R2 at1 write reaches tag only via V/D", d, 32'h0000_0300);
  endtask

  task automatic t_at2;
    logic [31:0] d;
    wr(AT2, 20, 32'hFFFF_FFFF);
    rd(AT2 | (20 << 8), d); check("R6 at2 pack", d, 32'h0000_000F);
    rd(AT1 | (20 << 8), d); check("R6 at1 untouched by at2", d, 32'd0);
    rd(AT1 | (13 << 8), d);
    check("R8 rdata after read", d, 32'h1FFF_FDFF);
    repeat (3) @(negedge clk);
    check("R8 rdata held without read", bus_rdata, 32'h1FFF_FDFF);
  endtask

  task automatic t_shared;
    logic [31:0] d;
    wr(TAG, 7, 32'h0000_0300);
    rd(AT1 | (7 << 8), d); check("R7 V/D from tag seen in at1", d, 32'h0000_0104);
    wr(AT1, 7, 32'h0000_0000);
    rd(TAG | (7 << 8), d); check("R7 V/D cleared via at1", d, 32'd0);
  endtask

  task automatic t_assoc;
    logic [31:0] d;
    @(negedge clk);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = TAG | (3 << 8) | 32'h80; bus_wdata = 32'd0;
    @(negedge clk);
    bus_vld = 1'b0; bus_we = 1'b0;
    check("R13 err pulse high", {31'd0, assoc_err}, 32'd1);
    @(negedge clk);
    check("R13 err pulse one cycle", {31'd0, assoc_err}, 32'd0);
    rd(TAG | (3 << 8), d); check("R13 entry unchanged", d, 32'hABCD_E7A5);
  endtask

  task automatic t_remap;
    logic [31:0] o;
    wr(TAG, 40, 32'h8C00_0000); wr(AT1, 40, 32'h0550_0000);
    remap(1'b0, 32'h8C0A_BCDE, o); check("R9 bypass when disabled", o, 32'h8C0A_BCDE);
    remap(1'b1, 32'h8C0A_BCDE, o); check("R10 hit substitutes", o, 32'h055A_BCDE);
    remap(1'b1, 32'h8C1A_BCDE, o); check("R11 miss passes", o, 32'h8C1A_BCDE);
    wr(TAG, 50, 32'h8C00_0000); wr(AT1, 50, 32'h0770_0000);
    remap(1'b1, 32'h8C00_0001, o); check("R12 lower of 40/50 wins", o, 32'h0550_0001);
    wr(TAG, 2, 32'h8C00_0000); wr(AT1, 2, 32'h0110_0000);
    remap(1'b1, 32'h8C0F_FFFF, o); check("R12 entry 2 wins", o, 32'h011F_FFFF);
    wr(TAG, 63, 32'h9000_0000); wr(AT1, 63, 32'h1FF0_0000);
    remap(1'b1, 32'h9001_2345, o); check("R10 hit at entry 63", o, 32'h1FF1_2345);
    remap(1'b0, 32'h9001_2345, o); check("R9 bypass entry 63", o, 32'h9001_2345);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tag();
    t_at1();
    t_at2();
    t_shared();
    t_assoc();
    t_remap();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule